// File: doc/BRIEF.md
# Cuckoo Table Column with Forwarding

This block is one column of a cuckoo hash loop. It owns a single table of slots, each holding a key, a value and a separately stored valid bit, and it places entries by its own hash of the key. An entry arriving from the previous column, either a fresh insert or an entry displaced upstream, is written into its slot. Whatever occupied that slot is handed to the next column as an outgoing eviction. The column can take one incoming entry per cycle. An entry that lands in an empty slot produces no eviction.

At the same time the column answers lookups. A lookup is never stalled: it always gets the table's read port, and its presence flag and value come back a fixed number of cycles later. In that return cycle the user may replace the value or delete the entry. The change counts as having happened in the cycle the lookup was issued, so a lookup of the same key issued one cycle later already sees it. This allows read-modify-write on consecutive cycles. An incoming entry that loses the read port to a lookup is parked in a one-entry holding register and replayed in the next cycle without a lookup. Every table write lags its read by the lookup latency. Reads still in flight are patched from the write port, so results are never stale.

The outgoing eviction is a valid, key and value bundle with no backpressure.

Top module: `cuckoo_col`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_vld` and `ev_vld` stay low until a request arrives. Every slot starts empty, so a lookup right after reset misses.
- R2: The slot of a key is `SEED` (low `AW` bits) XOR-ed with every key bit: bit i of the key toggles slot bit (i mod `AW`).
- R3: An incoming entry (`ins_vld`) whose slot is empty is stored and raises no `ev_vld`. A later lookup of its key hits and returns its value.
- R4: `rsp_vld` is high exactly `P` cycles after a cycle with `lk_req` high, and at no other time. `rsp_hit` and `rsp_val` are valid in that cycle, and `rsp_val` is 0 on a miss.
- R5: An incoming entry whose slot holds a valid entry replaces it. The old key and value appear on `ev_key`/`ev_val` with `ev_vld` high `P` cycles after the cycle the slot was read.
- R6: When `lk_req` and `ins_vld` are high in the same cycle, the lookup reads the table. The incoming entry is parked and is read in the next cycle with `lk_req` low, so its eviction comes `P` cycles after that cycle. A lookup of a key that is parked, or arriving in the same cycle, hits with that entry's value.
- R7: In a return cycle with `rsp_hit` high from a table entry, `upd_mod` replaces the value with `upd_val`. Any lookup issued in a later cycle, including the very next one, returns the new value.
- R8: In such a return cycle, `upd_del` clears the entry's valid bit, and later lookups miss. `upd_del` takes priority over `upd_mod`.
- R9: `upd_mod`/`upd_del` have no effect when the lookup missed, or when its hit came from the parked or arriving entry.
- R10: A lookup issued after an entry's slot read but before its write returns the new entry. A modify of an entry whose slot is being read for an eviction is carried by the outgoing eviction.
- R11: Every table write goes to the read address of exactly `P` cycles earlier.
- R12: `ins_vld` is never presented while an entry is parked; the column relies on this input rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_key | input | KW | Lookup key |
| rsp_vld | output | 1 | Lookup result cycle |
| rsp_hit | output | 1 | Key present |
| rsp_val | output | VW | Value of the key, 0 on miss |
| upd_mod | input | 1 | Replace value of the returned key (sampled when `rsp_vld`) |
| upd_del | input | 1 | Delete the returned key (sampled when `rsp_vld`) |
| upd_val | input | VW | Replacement value |
| ins_vld | input | 1 | Incoming entry from previous column |
| ins_key | input | KW | Incoming key |
| ins_val | input | VW | Incoming value |
| ev_vld | output | 1 | Outgoing eviction to next column |
| ev_key | output | KW | Evicted key |
| ev_val | output | VW | Evicted value |

## Verification
The placement path is tried with entries into empty slots and into a slot that two keys share. These cases separate a correct hash and a silent store from a spurious or missing eviction. Lookups that coincide with incoming entries show whether lookups win the port, whether the parked entry is visible and read-only, and whether its eviction comes one cycle late. Back-to-back lookups with modifies and deletes in the return cycle tell a design that forwards pending writes from one that returns stale table data. A modify that overlaps an eviction read of the same slot shows whether the outgoing entry carries the newest value.

// File: rtl/ckc_pkg.sv
`timescale 1ns/1ps
package ckc_pkg;
  // What a pipeline stage is carrying.
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_LOOK  = 2'd1,
    RK_EVICT = 2'd2
  } rd_kind_e;

  // Which request owns the read port this cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOOK = 2'd1,
    SRC_PARK = 2'd2,
    SRC_IN   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/ckc_store.sv
`timescale 1ns/1ps
module ckc_store #(
  parameter int KW = 16,
  parameter int VW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  output logic          rd_v,
  output logic [KW-1:0] rd_k,
  output logic [VW-1:0] rd_d,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic          wv,
  input  logic [KW-1:0] wk,
  input  logic [VW-1:0] wd
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] vbits;
  logic [KW-1:0]    kmem [DEPTH];
  logic [VW-1:0]    dmem [DEPTH];

  // Valid bits live apart from keys and values and are the only reset state.
  always_ff @(posedge clk) begin
    if (!rst_n)  vbits     <= '0;
    else if (we) vbits[wa] <= wv;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      kmem[wa] <= wk;
      dmem[wa] <= wd;
    end
  end

  // Read-before-write; the stage pipeline patches a same-cycle write.
  assign rd_v = vbits[rd_a];
  assign rd_k = kmem[rd_a];
  assign rd_d = dmem[rd_a];
endmodule

// File: rtl/ckc_park.sv
`timescale 1ns/1ps
module ckc_park import ckc_pkg::*; #(
  parameter int KW = 16,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_req,
  input  logic          ins_vld,
  input  logic [KW-1:0] ins_key,
  input  logic [VW-1:0] ins_val,
  output logic          pk_vld,
  output logic [KW-1:0] pk_key,
  output logic [VW-1:0] pk_val,
  output rd_src_e       src
);
  // Lookup first, then the parked entry, then a new arrival.
  always_comb begin
    if (lk_req)       src = SRC_LOOK;
    else if (pk_vld)  src = SRC_PARK;
    else if (ins_vld) src = SRC_IN;
    else              src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_vld <= 1'b0;
      pk_key <= '0;
      pk_val <= '0;
    end else if (lk_req && ins_vld) begin
      pk_vld <= 1'b1;
      pk_key <= ins_key;
      pk_val <= ins_val;
    end else if (!lk_req && pk_vld) begin
      pk_vld <= 1'b0;
    end
  end

  a_r12_no_arrival_while_parked: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld |-> !pk_vld);
  a_r6_park_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && ins_vld) |=> pk_vld);
  a_r6_replay_drains_park: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_vld && !lk_req) |=> !pk_vld);
endmodule

// File: rtl/ckc_pipe.sv
`timescale 1ns/1ps
module ckc_pipe import ckc_pkg::*; #(
  parameter int KW = 16,
  parameter int VW = 16,
  parameter int AW = 4,
  parameter int P  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_kind_e      cap_kind,
  input  logic [AW-1:0] cap_addr,
  input  logic          cap_ov,
  input  logic [KW-1:0] cap_ok,
  input  logic [VW-1:0] cap_od,
  input  logic [KW-1:0] cap_tk,
  input  logic [VW-1:0] cap_tv,
  input  logic          cap_ph,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_v,
  input  logic [KW-1:0] wr_k,
  input  logic [VW-1:0] wr_d,
  output rd_kind_e      ret_kind,
  output logic [AW-1:0] ret_a,
  output logic          ret_ov,
  output logic [KW-1:0] ret_ok,
  output logic [VW-1:0] ret_od,
  output logic [KW-1:0] ret_tk,
  output logic [VW-1:0] ret_tv,
  output logic          ret_ph
);
  // ov/ok/od: slot occupant as read; tk/tv: request key and its carried value.
  typedef struct packed {
    rd_kind_e      kind;
    logic [AW-1:0] a;
    logic          ov;
    logic [KW-1:0] ok;
    logic [VW-1:0] od;
    logic [KW-1:0] tk;
    logic [VW-1:0] tv;
    logic          ph;
  } stg_t;

  // Any write to a slot that a stage holds replaces the stage's copy.
  function automatic stg_t patch(input stg_t s, input logic we,
                                 input logic [AW-1:0] wa, input logic wv,
                                 input logic [KW-1:0] wk, input logic [VW-1:0] wd);
    stg_t r;
    r = s;
    if (s.kind != RK_NONE && we && wa == s.a) begin
      r.ov = wv;
      r.ok = wk;
      r.od = wd;
    end
    return r;
  endfunction

  stg_t cap_s;
  stg_t st [P];

  always_comb begin
    cap_s.kind = cap_kind;
    cap_s.a    = cap_addr;
    cap_s.ov   = cap_ov;
    cap_s.ok   = cap_ok;
    cap_s.od   = cap_od;
    cap_s.tk   = cap_tk;
    cap_s.tv   = cap_tv;
    cap_s.ph   = cap_ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < P; i++) st[i] <= '0;
    end else begin
      st[0] <= patch(cap_s, wr_en, wr_addr, wr_v, wr_k, wr_d);
      for (int i = 1; i < P; i++)
        st[i] <= patch(st[i-1], wr_en, wr_addr, wr_v, wr_k, wr_d);
    end
  end

  assign ret_kind = st[P-1].kind;
  assign ret_a    = st[P-1].a;
  assign ret_ov   = st[P-1].ov;
  assign ret_ok   = st[P-1].ok;
  assign ret_od   = st[P-1].od;
  assign ret_tk   = st[P-1].tk;
  assign ret_tv   = st[P-1].tv;
  assign ret_ph   = st[P-1].ph;
endmodule

// File: rtl/cuckoo_col.sv
`timescale 1ns/1ps
module cuckoo_col import ckc_pkg::*; #(
  parameter int KW   = 16,
  parameter int VW   = 16,
  parameter int AW   = 4,
  parameter int P    = 2,
  parameter int SEED = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_req,
  input  logic [KW-1:0] lk_key,
  output logic          rsp_vld,
  output logic          rsp_hit,
  output logic [VW-1:0] rsp_val,
  input  logic          upd_mod,
  input  logic          upd_del,
  input  logic [VW-1:0] upd_val,
  input  logic          ins_vld,
  input  logic [KW-1:0] ins_key,
  input  logic [VW-1:0] ins_val,
  output logic          ev_vld,
  output logic [KW-1:0] ev_key,
  output logic [VW-1:0] ev_val
);
  localparam logic [AW-1:0] SEED_BITS = AW'(SEED);

  // R2: every key bit toggles slot bit (i mod AW), starting from the seed.
  function automatic logic [AW-1:0] slot_of(input logic [KW-1:0] k);
    logic [AW-1:0] h;
    h = SEED_BITS;
    for (int i = 0; i < KW; i++) h[i % AW] = h[i % AW] ^ k[i];
    return h;
  endfunction

  // Named internal events
  rd_src_e       src;
  logic          pk_vld;
  logic [KW-1:0] pk_key;
  logic [VW-1:0] pk_val;
  logic [AW-1:0] rd_addr;
  logic          rd_v;
  logic [KW-1:0] rd_k;
  logic [VW-1:0] rd_d;
  rd_kind_e      cap_kind;
  logic [KW-1:0] cap_tk;
  logic [VW-1:0] cap_tv;
  logic          cap_ph;
  logic          park_match;
  logic          arr_match;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_v;
  logic [KW-1:0] wr_k;
  logic [VW-1:0] wr_d;
  rd_kind_e      ret_kind;
  logic [AW-1:0] ret_a;
  logic          ret_ov;
  logic [KW-1:0] ret_ok;
  logic [VW-1:0] ret_od;
  logic [KW-1:0] ret_tk;
  logic [VW-1:0] ret_tv;
  logic          ret_ph;
  logic          ret_look;
  logic          ret_evict;
  logic          ram_hit;
  logic          upd_take;

  ckc_park #(.KW(KW), .VW(VW)) u_park (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req),
    .ins_vld(ins_vld), .ins_key(ins_key), .ins_val(ins_val),
    .pk_vld(pk_vld), .pk_key(pk_key), .pk_val(pk_val), .src(src)
  );

  // Read-port source and what the stage carries with it.
  assign park_match = pk_vld && pk_key == lk_key;
  assign arr_match  = ins_vld && ins_key == lk_key;

  always_comb begin
    rd_addr  = '0;
    cap_kind = RK_NONE;
    cap_tk   = '0;
    cap_tv   = '0;
    cap_ph   = 1'b0;
    case (src)
      SRC_LOOK: begin
        rd_addr  = slot_of(lk_key);
        cap_kind = RK_LOOK;
        cap_tk   = lk_key;
        cap_ph   = park_match || arr_match;
        cap_tv   = park_match ? pk_val : ins_val;
      end
      SRC_PARK: begin
        rd_addr  = slot_of(pk_key);
        cap_kind = RK_EVICT;
        cap_tk   = pk_key;
        cap_tv   = pk_val;
      end
      SRC_IN: begin
        rd_addr  = slot_of(ins_key);
        cap_kind = RK_EVICT;
        cap_tk   = ins_key;
        cap_tv   = ins_val;
      end
      default: ;
    endcase
  end

  ckc_store #(.KW(KW), .VW(VW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_a(rd_addr),
    .rd_v(rd_v), .rd_k(rd_k), .rd_d(rd_d),
    .we(wr_en), .wa(wr_addr), .wv(wr_v), .wk(wr_k), .wd(wr_d)
  );

  ckc_pipe #(.KW(KW), .VW(VW), .AW(AW), .P(P)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .cap_kind(cap_kind), .cap_addr(rd_addr),
    .cap_ov(rd_v), .cap_ok(rd_k), .cap_od(rd_d),
    .cap_tk(cap_tk), .cap_tv(cap_tv), .cap_ph(cap_ph),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_v(wr_v), .wr_k(wr_k), .wr_d(wr_d),
    .ret_kind(ret_kind), .ret_a(ret_a), .ret_ov(ret_ov), .ret_ok(ret_ok),
    .ret_od(ret_od), .ret_tk(ret_tk), .ret_tv(ret_tv), .ret_ph(ret_ph)
  );

  // Return stage: lookup answer, modify/delete writeback or placement write.
  assign ret_look  = ret_kind == RK_LOOK;
  assign ret_evict = ret_kind == RK_EVICT;
  assign ram_hit   = ret_ov && ret_ok == ret_tk;

  assign rsp_vld = ret_look;
  assign rsp_hit = ret_look && (ret_ph || ram_hit);
  assign rsp_val = !rsp_hit ? '0 : (ret_ph ? ret_tv : ret_od);

  assign upd_take = ret_look && !ret_ph && ram_hit && (upd_mod || upd_del);

  assign wr_en   = ret_evict || upd_take;
  assign wr_addr = ret_a;
  assign wr_k    = ret_evict ? ret_tk : ret_ok;
  assign wr_d    = ret_evict ? ret_tv : (upd_mod && !upd_del ? upd_val : ret_od);
  assign wr_v    = ret_evict || !upd_del;

  assign ev_vld = ret_evict && ret_ov;
  assign ev_key = ret_ok;
  assign ev_val = ret_od;

  a_r11_write_lags_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr == $past(rd_addr, P));
  a_r4_response_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(lk_req, P));
  a_r5_one_use_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld |-> !rsp_vld);
  a_r9_no_update_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |-> !upd_take);
endmodule

// File: tb/cuckoo_col_tb.sv
`timescale 1ns/1ps
module cuckoo_col_tb;
  localparam int KW = 16;
  localparam int VW = 16;
  localparam int AW = 4;
  localparam int P  = 2;   // scenario timing below is written for P = 2
  localparam int SEED = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_req, upd_mod, upd_del, ins_vld;
  logic [KW-1:0] lk_key, ins_key;
  logic [VW-1:0] upd_val, ins_val;
  logic          rsp_vld, rsp_hit, ev_vld;
  logic [VW-1:0] rsp_val, ev_val;
  logic [KW-1:0] ev_key;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cuckoo_col #(.KW(KW), .VW(VW), .AW(AW), .P(P), .SEED(SEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_key(lk_key),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_val(rsp_val),
    .upd_mod(upd_mod), .upd_del(upd_del), .upd_val(upd_val),
    .ins_vld(ins_vld), .ins_key(ins_key), .ins_val(ins_val),
    .ev_vld(ev_vld), .ev_key(ev_key), .ev_val(ev_val)
  );

  // Bench view of R2: nibble-wise XOR fold plus seed.
  function automatic logic [3:0] slot_ref(input logic [15:0] k);
    return k[15:12] ^ k[11:8] ^ k[7:4] ^ k[3:0] ^ 4'(SEED);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    lk_req = 0; lk_key = '0; upd_mod = 0; upd_del = 0; upd_val = '0;
    ins_vld = 0; ins_key = '0; ins_val = '0;
  endtask

  task automatic lookup_chk(input string req, input logic [15:0] k,
                            input logic eh, input logic [15:0] ev);
    lk_req = 1; lk_key = k;
    tick();
    clr();
    repeat (P-1) tick();
    check(req, "rsp_vld", 32'(rsp_vld), 32'd1);
    check(req, "rsp_hit", 32'(rsp_hit), 32'(eh));
    check(req, "rsp_val", 32'(rsp_val), 32'(ev));
    tick();
  endtask

  // Incoming entry with no lookup; check eviction P cycles later.
  task automatic place_chk(input string req, input logic [15:0] k, input logic [15:0] v,
                           input logic eev, input logic [15:0] ek, input logic [15:0] evl);
    ins_vld = 1; ins_key = k; ins_val = v;
    tick();
    clr();
    check(req, "no early ev_vld", 32'(ev_vld), 32'd0);
    repeat (P-1) tick();
    check(req, "ev_vld", 32'(ev_vld), 32'(eev));
    if (eev) begin
      check(req, "ev_key", 32'(ev_key), 32'(ek));
      check(req, "ev_val", 32'(ev_val), 32'(evl));
    end
    repeat (2) tick();
  endtask

  task automatic t_reset();
    check("R1", "rsp_vld after reset", 32'(rsp_vld), 32'd0);
    check("R1", "ev_vld after reset", 32'(ev_vld), 32'd0);
    // R4: not early
    lk_req = 1; lk_key = 16'h0001;
    tick();
    clr();
    check("R4", "rsp_vld one cycle early", 32'(rsp_vld), 32'd0);
    tick();
    check("R4", "rsp_vld", 32'(rsp_vld), 32'd1);
    check("R1", "empty table miss", 32'(rsp_hit), 32'd0);
    check("R4", "miss value zero", 32'(rsp_val), 32'd0);
    tick();
    check("R4", "rsp_vld drops", 32'(rsp_vld), 32'd0);
  endtask

  task automatic t_place();
    // slot_ref(0001)=slot_ref(0100)=4, slot_ref(0030)=6
    check("R2", "bench slot pair", 32'(slot_ref(16'h0001) == slot_ref(16'h0100)), 32'd1);
    place_chk("R3", 16'h0001, 16'hAAAA, 1'b0, '0, '0);
    lookup_chk("R3", 16'h0001, 1'b1, 16'hAAAA);
    place_chk("R5", 16'h0100, 16'hBBBB, 1'b1, 16'h0001, 16'hAAAA);  // R2 shared slot
    lookup_chk("R5", 16'h0100, 1'b1, 16'hBBBB);
    lookup_chk("R5", 16'h0001, 1'b0, 16'h0000);
  endtask

  task automatic t_park();
    // cycle c: lookup 0030 (absent) with arrival 0011 -> parked
    lk_req = 1; lk_key = 16'h0030; ins_vld = 1; ins_key = 16'h0011; ins_val = 16'h1111;
    tick();
    clr();
    lk_req = 1; lk_key = 16'h0011;          // c+1: parked key looked up
    tick();
    clr();                                  // c+2: park replays, answer of c
    check("R6", "lookup wins rsp_vld", 32'(rsp_vld), 32'd1);
    check("R6", "lookup wins miss", 32'(rsp_hit), 32'd0);
    tick();                                 // c+3: answer of c+1 from park
    check("R6", "parked hit", 32'(rsp_hit), 32'd1);
    check("R6", "parked value", 32'(rsp_val), 32'h1111);
    upd_mod = 1; upd_val = 16'h9999;        // R9: must be ignored
    tick();
    clr();                                  // c+4: replay result, slot 5 empty
    check("R6", "replay into empty slot", 32'(ev_vld), 32'd0);
    repeat (2) tick();
    lookup_chk("R9", 16'h0011, 1'b1, 16'h1111);

    // arrival 0022 (slot 5, occupied) collides with lookup of 0011
    lk_req = 1; lk_key = 16'h0011; ins_vld = 1; ins_key = 16'h0022; ins_val = 16'h2222;
    tick();
    clr();                                  // c+1: replay read
    tick();                                 // c+2
    check("R6", "lookup during collision", 32'(rsp_val), 32'h1111);
    check("R6", "no eviction at c+P", 32'(ev_vld), 32'd0);
    tick();                                 // c+3
    check("R6", "replayed eviction", 32'(ev_vld), 32'd1);
    check("R6", "replayed ev_key", 32'(ev_key), 32'h0011);
    check("R6", "replayed ev_val", 32'(ev_val), 32'h1111);
    repeat (2) tick();
    lookup_chk("R6", 16'h0022, 1'b1, 16'h2222);
  endtask

  task automatic t_rmw();
    logic [15:0] exp_v;
    exp_v = 16'hBBBB;
    for (int i = 0; i < 3 + P; i++) begin
      clr();
      lk_req = (i < 3); lk_key = 16'h0100;
      if (i >= P) begin
        check("R7", "b2b hit", 32'(rsp_hit), 32'd1);
        check("R7", "b2b value", 32'(rsp_val), 32'(exp_v));
        upd_mod = 1; upd_val = exp_v + 16'h1;
        exp_v = exp_v + 16'h1;
      end
      tick();
    end
    clr();
    repeat (2) tick();
    lookup_chk("R7", 16'h0100, 1'b1, 16'hBBBE);
  endtask

  task automatic t_delete();
    lk_req = 1; lk_key = 16'h0100;
    tick();
    tick();                                 // still requesting: second lookup
    clr();
    check("R8", "hit before delete", 32'(rsp_hit), 32'd1);
    upd_del = 1; upd_mod = 1; upd_val = 16'h1234;  // delete wins
    tick();
    clr();
    check("R8", "next-cycle lookup sees delete", 32'(rsp_hit), 32'd0);
    repeat (2) tick();
    lookup_chk("R8", 16'h0100, 1'b0, 16'h0000);
  endtask

  task automatic t_ignore();
    lk_req = 1; lk_key = 16'h0777;
    tick();
    clr();
    tick();
    check("R9", "miss", 32'(rsp_hit), 32'd0);
    upd_mod = 1; upd_val = 16'h5555;
    tick();
    clr();
    repeat (2) tick();
    lookup_chk("R9", 16'h0777, 1'b0, 16'h0000);
  endtask

  task automatic t_forward();
    ins_vld = 1; ins_key = 16'h0030; ins_val = 16'h3030;
    tick();
    clr();
    lk_req = 1; lk_key = 16'h0030;          // after read, before write
    tick();
    clr();
    tick();
    check("R10", "in-flight entry hit", 32'(rsp_hit), 32'd1);
    check("R10", "in-flight entry value", 32'(rsp_val), 32'h3030);
    repeat (2) tick();

    place_chk("R8", 16'h0001, 16'h0101, 1'b0, '0, '0);  // deleted slot is empty
    lk_req = 1; lk_key = 16'h0001;          // t
    tick();
    clr();
    ins_vld = 1; ins_key = 16'h1000; ins_val = 16'h1010;  // t+1 reads slot 4
    tick();
    clr();                                  // t+2
    check("R10", "hit to modify", 32'(rsp_val), 32'h0101);
    upd_mod = 1; upd_val = 16'h0202;
    tick();
    clr();                                  // t+3
    check("R10", "eviction", 32'(ev_vld), 32'd1);
    check("R10", "eviction key", 32'(ev_key), 32'h0001);
    check("R10", "eviction carries modify", 32'(ev_val), 32'h0202);
    repeat (2) tick();
    lookup_chk("R3", 16'h1000, 1'b1, 16'h1010);
  endtask

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rsp_vld in reset", 32'(rsp_vld), 32'd0);
    check("R1", "ev_vld in reset", 32'(ev_vld), 32'd0);
    rst_n = 1;
    tick();
    t_reset();
    t_place();
    t_park();
    t_rmw();
    t_delete();
    t_ignore();
    t_forward();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule